// File: doc/BRIEF.md
# Bidirectional Doorbell Mailbox

This block lets a system control processor and an application processor ring each other's doorbells. For each channel it holds two 32-bit flag words, one per direction. Each word can be seen through three windows: a read-only window that shows its value, a window where written ones are added to the word, and a window where written ones are removed from it. While a flag word is nonzero, a level interrupt is raised toward the processor that receives in that direction. The receiver clears the bits it has serviced, and the sender knows its message has been taken once the word reads back as zero.

There are three channels: low priority at index 0, high priority at index 1 and a protected channel at index 2. The protected channel can only be reached by accesses that carry the secure flag. Two identical register ports, one per processor, share a single register map. Either port may add or remove flags in either direction. Read data is registered and appears one cycle after the address is presented.

Top module: `dbell_mbox_top`

## Requirements
- R1: After a synchronous reset, every flag word, every interrupt output and both read data outputs are zero.
- R2: The address decodes as follows. Bit 8 selects the direction: 0 means toward the application processor, 1 means toward the control processor. Bits 7:5 select the channel. Bits 4:0 select the window: 0x00 reads the value, 0x08 adds flags, 0x10 removes flags. Bit 9 must be zero.
- R3: A write to an add window ORs the write data into the selected flag word.
- R4: A write to a remove window clears every bit that is 1 in the write data. A write of all ones empties the word.
- R5: Interrupt bit c of `irq_ap` (direction 0) or of `irq_cp` (direction 1) equals the OR-reduction of that flag word as it stood one clock earlier. It stays high until every bit has been cleared.
- R6: A write to channel 2 without the secure flag leaves both of that channel's words unchanged.
- R7: A read of channel 2 without the secure flag returns zero.
- R8: When an add and a remove reach the same word in the same cycle, the removal wins for the bits they share. The other added bits are still set.
- R9: Reads of the add and remove windows, of channel indexes 3 to 7, of other window offsets and of any address with bit 9 set all return zero. Writes to value windows or to unmapped addresses change no word.
- R10: Read data appears on the port's `rdata` one cycle after the address. It shows the word as it stood before any write taking effect on that same clock edge.
- R11: Both ports decode the same map and have equal rights. Writes from the two ports in one cycle are merged into the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_addr | input | 10 | Port A byte address |
| a_we | input | 1 | Port A write strobe |
| a_wdata | input | 32 | Port A write data |
| a_sec | input | 1 | Port A secure-access flag |
| a_rdata | output | 32 | Port A registered read data |
| b_addr | input | 10 | Port B byte address |
| b_we | input | 1 | Port B write strobe |
| b_wdata | input | 32 | Port B write data |
| b_sec | input | 1 | Port B secure-access flag |
| b_rdata | output | 32 | Port B registered read data |
| irq_ap | output | 3 | Per-channel level interrupt toward the application processor |
| irq_cp | output | 3 | Per-channel level interrupt toward the control processor |

## Verification
Two collisions can land on one flag word in a single cycle. The first is an add from one port together with a remove from the other. The second is a write together with a read of the same word. The bench provokes the first with a directed pair of overlapping masks on the two ports, and in random traffic whenever both ports pick the same word. It judges the result by the next read, which must equal (old | added) & ~removed. For the second, every operation compares the read data against the bench model's value from before that cycle's update. A design that forwards the new value, or lets the add win, therefore fails on the first collision.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  // window offsets inside a channel's slot
  localparam logic [4:0] OFS_STAT = 5'h00;
  localparam logic [4:0] OFS_SET  = 5'h08;
  localparam logic [4:0] OFS_CLR  = 5'h10;
  // address field positions
  localparam int CH_SHIFT = 5;   // channel slot stride 0x20
  localparam int DIR_BIT  = 8;   // direction block stride 0x100
  localparam int CH_W     = DIR_BIT - CH_SHIFT;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_STAT = 2'd1,
    K_SET  = 2'd2,
    K_CLR  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/dbell_port_dec.sv
module dbell_port_dec
  import dbell_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int SEC_CH = 2,
  parameter int DW     = 32,
  parameter int AW     = 10
) (
  input  logic [AW-1:0]          addr,
  input  logic                   we,
  input  logic [DW-1:0]          wdata,
  input  logic                   sec,
  output logic [2*NUM_CH*DW-1:0] set_m,
  output logic [2*NUM_CH*DW-1:0] clr_m,
  output logic                   hit_stat,
  output logic [$clog2(2*NUM_CH)-1:0] widx
);
  localparam int NW     = 2 * NUM_CH;
  localparam int WIDX_W = $clog2(NW);

  logic [CH_W-1:0] ch;
  logic            dir;
  logic            upper_ok;
  logic            ok;
  acc_kind_e       kind;

  always_comb begin
    ch       = addr[DIR_BIT-1:CH_SHIFT];
    dir      = addr[DIR_BIT];
    upper_ok = (addr[AW-1:DIR_BIT+1] == '0);
    case (addr[CH_SHIFT-1:0])
      OFS_STAT: kind = K_STAT;
      OFS_SET:  kind = K_SET;
      OFS_CLR:  kind = K_CLR;
      default:  kind = K_NONE;
    endcase
    ok       = upper_ok && (int'(ch) < NUM_CH) && (sec || (int'(ch) != SEC_CH));
    widx     = WIDX_W'(ch) + (dir ? WIDX_W'(NUM_CH) : WIDX_W'(0));
    hit_stat = ok && (kind == K_STAT);
  end

  for (genvar w = 0; w < NW; w++) begin : g_mask
    logic sel;
    assign sel = ok && we && (widx == WIDX_W'(w));
    assign set_m[w*DW +: DW] = (sel && kind == K_SET) ? wdata : '0;
    assign clr_m[w*DW +: DW] = (sel && kind == K_CLR) ? wdata : '0;
  end
endmodule

// File: rtl/dbell_word.sv
module dbell_word #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] set_in,
  input  logic [DW-1:0] clr_in,
  output logic [DW-1:0] stat_q,
  output logic          irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      // removal dominates overlapping bits
      stat_q <= (stat_q | set_in) & ~clr_in;
      irq_q  <= |stat_q;
    end
  end
endmodule

// File: rtl/dbell_rd_port.sv
module dbell_rd_port #(
  parameter int NW = 6,
  parameter int DW = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hit,
  input  logic [$clog2(NW)-1:0] widx,
  input  logic [NW*DW-1:0]      words,
  output logic [DW-1:0]         rdata_q
);
  logic [DW-1:0] sel_word;

  always_comb begin
    sel_word = '0;
    for (int w = 0; w < NW; w++) begin
      if (int'(widx) == w) sel_word = words[w*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= hit ? sel_word : '0;
  end
endmodule

// File: rtl/dbell_mbox_top.sv
module dbell_mbox_top #(
  parameter int NUM_CH = 3,
  parameter int SEC_CH = 2,
  parameter int DW     = 32,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     a_addr,
  input  logic              a_we,
  input  logic [DW-1:0]     a_wdata,
  input  logic              a_sec,
  output logic [DW-1:0]     a_rdata,
  input  logic [AW-1:0]     b_addr,
  input  logic              b_we,
  input  logic [DW-1:0]     b_wdata,
  input  logic              b_sec,
  output logic [DW-1:0]     b_rdata,
  output logic [NUM_CH-1:0] irq_ap,
  output logic [NUM_CH-1:0] irq_cp
);
  localparam int NPORT  = 2;
  localparam int NW     = 2 * NUM_CH;
  localparam int WIDX_W = $clog2(NW);

  logic [AW-1:0]     p_addr  [NPORT];
  logic              p_we    [NPORT];
  logic [DW-1:0]     p_wdata [NPORT];
  logic              p_sec   [NPORT];
  logic [DW-1:0]     p_rdata [NPORT];
  logic [NW*DW-1:0]  p_set   [NPORT];
  logic [NW*DW-1:0]  p_clr   [NPORT];
  logic              p_hit   [NPORT];
  logic [WIDX_W-1:0] p_widx  [NPORT];

  logic [NW*DW-1:0]  set_all;
  logic [NW*DW-1:0]  clr_all;
  logic [NW*DW-1:0]  stat_flat;
  logic [NW-1:0]     irq_all;

  assign p_addr[0]  = a_addr;
  assign p_we[0]    = a_we;
  assign p_wdata[0] = a_wdata;
  assign p_sec[0]   = a_sec;
  assign p_addr[1]  = b_addr;
  assign p_we[1]    = b_we;
  assign p_wdata[1] = b_wdata;
  assign p_sec[1]   = b_sec;
  assign a_rdata    = p_rdata[0];
  assign b_rdata    = p_rdata[1];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dbell_port_dec #(.NUM_CH(NUM_CH), .SEC_CH(SEC_CH), .DW(DW), .AW(AW)) u_dec (
      .addr     (p_addr[p]),
      .we       (p_we[p]),
      .wdata    (p_wdata[p]),
      .sec      (p_sec[p]),
      .set_m    (p_set[p]),
      .clr_m    (p_clr[p]),
      .hit_stat (p_hit[p]),
      .widx     (p_widx[p])
    );
    dbell_rd_port #(.NW(NW), .DW(DW)) u_rd (
      .clk     (clk),
      .rst     (rst),
      .hit     (p_hit[p]),
      .widx    (p_widx[p]),
      .words   (stat_flat),
      .rdata_q (p_rdata[p])
    );
  end

  always_comb begin
    set_all = '0;
    clr_all = '0;
    for (int p = 0; p < NPORT; p++) begin
      set_all = set_all | p_set[p];
      clr_all = clr_all | p_clr[p];
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_word
    dbell_word #(.DW(DW)) u_word (
      .clk    (clk),
      .rst    (rst),
      .set_in (set_all[w*DW +: DW]),
      .clr_in (clr_all[w*DW +: DW]),
      .stat_q (stat_flat[w*DW +: DW]),
      .irq_q  (irq_all[w])
    );
  end

  assign irq_ap = irq_all[NUM_CH-1:0];
  assign irq_cp = irq_all[NW-1:NUM_CH];
endmodule

// File: rtl/dbell_chk.sv
module dbell_chk
  import dbell_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int SEC_CH = 2,
  parameter int DW     = 32,
  parameter int AW     = 10
) (
  input logic                   clk,
  input logic                   rst,
  input logic [AW-1:0]          a_addr,
  input logic                   a_we,
  input logic                   a_sec,
  input logic [DW-1:0]          a_rdata,
  input logic [AW-1:0]          b_addr,
  input logic                   b_we,
  input logic                   b_sec,
  input logic [DW-1:0]          b_rdata,
  input logic [2*NUM_CH*DW-1:0] set_all,
  input logic [2*NUM_CH*DW-1:0] clr_all,
  input logic [2*NUM_CH*DW-1:0] stat_flat,
  input logic [NUM_CH-1:0]      irq_ap,
  input logic [NUM_CH-1:0]      irq_cp
);
  localparam int SEC_LO = SEC_CH * DW;
  localparam int SEC_HI = (NUM_CH + SEC_CH) * DW;

  logic [NUM_CH-1:0] nz_ap, nz_cp;
  logic [2*DW-1:0]   sec_words;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      nz_ap[c] = |stat_flat[c*DW +: DW];
      nz_cp[c] = |stat_flat[(NUM_CH+c)*DW +: DW];
    end
    sec_words = {stat_flat[SEC_HI +: DW], stat_flat[SEC_LO +: DW]};
  end

  assert_irq_level_R5: assert property (@(posedge clk) disable iff (rst)
    (irq_ap == $past(nz_ap)) && (irq_cp == $past(nz_cp)));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_all != '0) |=> ((stat_flat & $past(clr_all)) == '0));

  assert_set_sticks_R3: assert property (@(posedge clk) disable iff (rst)
    ((set_all & ~clr_all) != '0) |=>
      ((stat_flat & $past(set_all & ~clr_all)) == $past(set_all & ~clr_all)));

  assert_secure_guard_R6: assert property (@(posedge clk) disable iff (rst)
    (!(a_we && a_sec) && !(b_we && b_sec)) |=> $stable(sec_words));

  assert_ns_read_a_R7: assert property (@(posedge clk) disable iff (rst)
    (!a_sec && (a_addr[DIR_BIT-1:CH_SHIFT] == CH_W'(SEC_CH))) |=> (a_rdata == '0));

  assert_ns_read_b_R7: assert property (@(posedge clk) disable iff (rst)
    (!b_sec && (b_addr[DIR_BIT-1:CH_SHIFT] == CH_W'(SEC_CH))) |=> (b_rdata == '0));
endmodule

bind dbell_mbox_top dbell_chk #(
  .NUM_CH(NUM_CH), .SEC_CH(SEC_CH), .DW(DW), .AW(AW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .a_addr    (a_addr),
  .a_we      (a_we),
  .a_sec     (a_sec),
  .a_rdata   (a_rdata),
  .b_addr    (b_addr),
  .b_we      (b_we),
  .b_sec     (b_sec),
  .b_rdata   (b_rdata),
  .set_all   (set_all),
  .clr_all   (clr_all),
  .stat_flat (stat_flat),
  .irq_ap    (irq_ap),
  .irq_cp    (irq_cp)
);

// File: tb/sim_dbell_mbox_top.sv
module sim_dbell_mbox_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  a_addr = '0, b_addr = '0;
  logic        a_we = 1'b0, b_we = 1'b0, a_sec = 1'b1, b_sec = 1'b1;
  logic [31:0] a_wdata = '0, b_wdata = '0;
  logic [31:0] a_rdata, b_rdata;
  logic [2:0]  irq_ap, irq_cp;

  int errors = 0;
  int checks = 0;
  logic [31:0] model [6];

  always #(CLK_P/2) clk = ~clk;

  dbell_mbox_top u0 (
    .clk(clk), .rst(rst),
    .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_sec(a_sec), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_we(b_we), .b_wdata(b_wdata), .b_sec(b_sec), .b_rdata(b_rdata),
    .irq_ap(irq_ap), .irq_cp(irq_cp)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // word index or -1 when the access reaches no word
  function automatic int bidx(input logic [9:0] ad, input logic sec);
    int ch;
    ch = int'(ad[7:5]);
    if (ad[9] || ch > 2 || (ch == 2 && !sec)) return -1;
    return int'(ad[8]) * 3 + ch;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [9:0] ad, input logic sec);
    int w;
    w = bidx(ad, sec);
    if (w < 0 || ad[4:0] != 5'h00) return 32'h0;
    return model[w];
  endfunction

  function automatic logic [2:0] nz(input int dir);
    logic [2:0] v;
    for (int c = 0; c < 3; c++) v[c] = |model[dir*3 + c];
    return v;
  endfunction

  // one cycle on both ports; checks read data and interrupts
  task automatic op(input string tag,
                    input logic awe, input logic [9:0] aad, input logic [31:0] awd, input logic asec,
                    input logic bwe, input logic [9:0] bad, input logic [31:0] bwd, input logic bsec);
    logic [31:0] ea, eb, sm, cm;
    logic [2:0]  eia, eic;
    int          wa, wb;
    ea = exp_rd(aad, asec);
    eb = exp_rd(bad, bsec);
    eia = nz(0);
    eic = nz(1);
    a_we = awe; a_addr = aad; a_wdata = awd; a_sec = asec;
    b_we = bwe; b_addr = bad; b_wdata = bwd; b_sec = bsec;
    @(posedge clk);
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0;
    check({tag, " rdata A"}, a_rdata, ea);
    check({tag, " rdata B"}, b_rdata, eb);
    check({tag, " irq_ap"}, {29'd0, irq_ap}, {29'd0, eia});
    check({tag, " irq_cp"}, {29'd0, irq_cp}, {29'd0, eic});
    wa = awe ? bidx(aad, asec) : -1;
    wb = bwe ? bidx(bad, bsec) : -1;
    for (int w = 0; w < 6; w++) begin
      sm = '0; cm = '0;
      if (wa == w && aad[4:0] == 5'h08) sm |= awd;
      if (wa == w && aad[4:0] == 5'h10) cm |= awd;
      if (wb == w && bad[4:0] == 5'h08) sm |= bwd;
      if (wb == w && bad[4:0] == 5'h10) cm |= bwd;
      model[w] = (model[w] | sm) & ~cm;
    end
  endtask

  task automatic wr_a(input string tag, input logic [9:0] ad, input logic [31:0] d, input logic s);
    op(tag, 1'b1, ad, d, s, 1'b0, 10'h0, 32'h0, 1'b1);
  endtask

  task automatic rd_a(input string tag, input logic [9:0] ad, input logic s, input logic [31:0] exp);
    op(tag, 1'b0, ad, 32'h0, s, 1'b0, 10'h0, 32'h0, 1'b1);
    check({tag, " direct"}, a_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int w = 0; w < 6; w++) model[w] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq_ap", {29'd0, irq_ap}, 32'h0);
    check("R1 irq_cp", {29'd0, irq_cp}, 32'h0);
    check("R1 rdata A", a_rdata, 32'h0);
    check("R1 rdata B", b_rdata, 32'h0);
    for (int w = 0; w < 6; w++) rd_a("R1 word", 10'((w / 3) * 256 + (w % 3) * 32), 1'b1, 32'h0);

    // R2, R3 map and OR-in
    wr_a("R3", 10'h008, 32'h0000_0005, 1'b1);
    wr_a("R3", 10'h008, 32'h0000_0030, 1'b1);
    rd_a("R3 ch0 ap", 10'h000, 1'b1, 32'h0000_0035);
    wr_a("R2", 10'h128, 32'hA000_0000, 1'b1);
    rd_a("R2 ch1 cp", 10'h120, 1'b1, 32'hA000_0000);
    rd_a("R2 ch1 ap", 10'h020, 1'b1, 32'h0);
    check("R2 irq_cp", {29'd0, irq_cp}, 32'h2);

    // R4 partial and full clear
    wr_a("R4", 10'h010, 32'h0000_0021, 1'b1);
    rd_a("R4 partial", 10'h000, 1'b1, 32'h0000_0014);
    wr_a("R4", 10'h130, 32'hFFFF_FFFF, 1'b1);
    rd_a("R4 full", 10'h120, 1'b1, 32'h0);

    // R5 one-cycle interrupt lag
    wr_a("R5", 10'h108, 32'h1, 1'b1);
    check("R5 lag", {31'd0, irq_cp[0]}, 32'h0);
    rd_a("R5", 10'h100, 1'b1, 32'h1);
    check("R5 raised", {31'd0, irq_cp[0]}, 32'h1);
    wr_a("R5", 10'h110, 32'h1, 1'b1);
    rd_a("R5", 10'h100, 1'b1, 32'h0);
    check("R5 dropped", {31'd0, irq_cp[0]}, 32'h0);

    // R6, R7 secure channel
    wr_a("R6", 10'h048, 32'h0000_00FF, 1'b0);
    rd_a("R6 ignored", 10'h040, 1'b1, 32'h0);
    wr_a("R6", 10'h148, 32'h0000_0F00, 1'b1);
    rd_a("R6 secure ok", 10'h140, 1'b1, 32'h0000_0F00);
    wr_a("R6", 10'h150, 32'hFFFF_FFFF, 1'b0);
    rd_a("R7 ns read", 10'h140, 1'b0, 32'h0);
    rd_a("R6 kept", 10'h140, 1'b1, 32'h0000_0F00);

    // R8 add on A, remove on B, same word same cycle
    op("R8", 1'b1, 10'h028, 32'hFF00_FF00, 1'b1, 1'b1, 10'h030, 32'h0F0F_0F0F, 1'b1);
    rd_a("R8 clear wins", 10'h020, 1'b1, 32'hF000_F000);

    // R9 zero windows and ignored writes
    rd_a("R9 set window", 10'h028, 1'b1, 32'h0);
    rd_a("R9 clr window", 10'h030, 1'b1, 32'h0);
    wr_a("R9", 10'h020, 32'h0000_00FF, 1'b1);
    wr_a("R9", 10'h068, 32'h0000_00FF, 1'b1);
    wr_a("R9", 10'h228, 32'h0000_00FF, 1'b1);
    wr_a("R9", 10'h038, 32'hFFFF_FFFF, 1'b1);
    rd_a("R9 untouched", 10'h020, 1'b1, 32'hF000_F000);
    rd_a("R9 unmapped ch", 10'h060, 1'b1, 32'h0);
    rd_a("R9 bit9", 10'h220, 1'b1, 32'h0);

    // R10 same-cycle read sees old value; R11 port B writes
    op("R10", 1'b0, 10'h000, 32'h0, 1'b1, 1'b1, 10'h008, 32'h0000_0100, 1'b1);
    op("R10", 1'b1, 10'h008, 32'h0000_0200, 1'b1, 1'b0, 10'h000, 32'h0, 1'b1);
    check("R10 old value B", b_rdata, 32'h0000_0114);
    op("R11", 1'b1, 10'h008, 32'h0000_1000, 1'b1, 1'b1, 10'h008, 32'h0000_2000, 1'b1);
    rd_a("R11 merged", 10'h000, 1'b1, 32'h0000_3314);

    // random mix, all checks against the model
    begin
      int unsigned seed;
      seed = $urandom(32'h1234_5678);
      for (int i = 0; i < 600; i++) begin
        logic [9:0]  ad [2];
        logic [31:0] d  [2];
        logic        we [2];
        logic        s  [2];
        for (int p = 0; p < 2; p++) begin
          logic [4:0] ofs;
          case ($urandom % 4)
            0: ofs = 5'h00;
            1: ofs = 5'h08;
            2: ofs = 5'h10;
            default: ofs = ($urandom % 8 == 0) ? 5'h18 : 5'h08;
          endcase
          ad[p] = {($urandom % 16 == 0) ? 1'b1 : 1'b0, 1'($urandom), 3'($urandom % 4), ofs};
          case ($urandom % 4)
            0: d[p] = 32'hFFFF_FFFF;
            1: d[p] = 32'h1 << ($urandom % 32);
            default: d[p] = $urandom;
          endcase
          we[p] = ($urandom % 10) < 7;
          s[p]  = ($urandom % 4) != 0;
        end
        op("R11 random", we[0], ad[0], d[0], s[0], we[1], ad[1], d[1], s[1]);
      end
      if (seed == 0) $display("seed note");
    end

    // final drain: every word read back
    for (int w = 0; w < 6; w++) rd_a("R2 final", 10'((w / 3) * 256 + (w % 3) * 32), 1'b1, model[w]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule